// File: doc/BRIEF.md
# Locked Bus Cycle Sequencer

This block starts cycles on a processor bus and sets the type code for each one. A requester offers one cycle at a time. Each cycle carries a 3-bit type and two flags: one asks for bus locking and one marks the last cycle of a locked run. When a cycle is accepted, the block drives a one-clock address strobe. The three cycle-definition bits are already valid in that same clock. The block then waits for the ready strobe. It drives the active-low lock output across a read-modify-write run, and any number of locked cycles may be chained into one run.

The block also decides between a full bus-hold request and the current bus owner. Between unlocked cycles, hold is granted and every bus output floats. During a locked run, hold is refused. An address-hold request is still honoured at any time: the address drivers float and no new cycle starts. A cache-enable input turns an unlocked memory or code read into a cache-fill indication. A locked read never becomes a cache fill.

Top module: `lockbus_seq`

## Requirements
- R1: The type of an accepted request appears on `cyc_def` = {memory/IO, data/control, write/read} in the clock where `ads_n` is low. The codes are: 000 interrupt acknowledge, 001 halt/special, 010 I/O read, 011 I/O write, 100 code read, 110 memory read, 111 memory write. `cyc_def` holds its value until the next strobe.
- R2: A request is accepted (`req_accept` high) only while no cycle is in progress. `ads_n` goes low for exactly the one clock after acceptance. The cycle stays in progress until `bus_ready` is sampled high, which may happen from the strobe clock onwards.
- R3: A request with type 101 is ignored. There is no accept, no strobe and no change to `cyc_def` or `lock_n`.
- R4: `lock_n` goes low in the strobe clock of the first cycle requested with `req_lock`. Every later cycle accepted while the lock is active is locked as well.
- R5: `lock_n` returns high in the clock after `bus_ready` for a locked cycle that was requested with `req_lock_end`. It stays low across the ready of every other locked cycle.
- R6: While `lock_n` is low, `hold_ack` stays low and requests keep being accepted, even when `hold_req` is high.
- R7: While `ahold_req` is high, `addr_oe` is low in the same clock and no request is accepted, whether or not the lock is active.
- R8: With no lock active and no cycle in progress, a high `hold_req` raises `hold_ack` in the next clock. Hold takes priority over a request offered in the same clock. A pending hold waits for the ready of the current cycle.
- R9: While `hold_ack` is high, `bus_oe` and `addr_oe` are low and no request is accepted. `hold_ack` drops in the clock after `hold_req` is sampled low.
- R10: `cache_fill` is high while an unlocked memory read (110) or code read (100) is in progress and `cache_en` is high. It is never high during a locked cycle or for any other type.
- R11: After a synchronous reset (`rst_n` low): `ads_n`=1, `lock_n`=1, `hold_ack`=0, `bus_oe`=1 and `cyc_def`=000, with no cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A cycle request is offered |
| req_type | input | 3 | Requested {memory/IO, data/control, write/read} |
| req_lock | input | 1 | Request starts or joins a locked run |
| req_lock_end | input | 1 | Request is the last cycle of the locked run |
| req_accept | output | 1 | Request taken this clock |
| bus_ready | input | 1 | Current cycle completes |
| hold_req | input | 1 | Full bus-hold request |
| ahold_req | input | 1 | Address-hold request |
| cache_en | input | 1 | Cache-enable returned for the current cycle |
| ads_n | output | 1 | Address strobe, active low |
| cyc_def | output | 3 | Cycle-definition bits |
| lock_n | output | 1 | Bus lock, active low |
| hold_ack | output | 1 | Bus-hold acknowledge |
| bus_oe | output | 1 | Drive enable for strobe, definition and lock pins |
| addr_oe | output | 1 | Drive enable for the address pins |
| cache_fill | output | 1 | Current cycle becomes a cache fill |

## Verification
Random runs mix all eight type codes with random ready timing, hold, address-hold and cache-enable. A reference model checks every output in every clock. Random runs alone would rarely hit some cases, so directed sequences cover them: a long locked chain with hold raised in the middle, which separates "hold deferred by lock" from "hold granted between cycles". A request and a hold offered in the same idle clock show which one wins. Address hold raised during a lock shows that it is honoured while full hold is refused. Locked and unlocked memory reads with cache-enable high separate cache-fill suppression from the read-type decode.

// File: rtl/lbc_pkg.sv
// Shared types for the locked bus cycle sequencer.
// Assumes a 3-bit cycle code ordered {memory/IO, data/control, write/read}.
package lbc_pkg;
    localparam int DEF_W = 3;
    typedef logic [DEF_W-1:0] cyc_def_t;

    localparam cyc_def_t CYC_RESERVED = 3'b101;
    localparam int BIT_MIO = 2;
    localparam int BIT_WR  = 0;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_HOLD = 2'd2
    } seq_state_t;
endpackage

// File: rtl/lbc_cycle_decode.sv
// Classifies a cycle code: whether it may be issued, and whether it is a
// read that the cache could fill (memory read or code read).
// Assumes: purely combinational, no state.
module lbc_cycle_decode
    import lbc_pkg::*;
(
    input  cyc_def_t code,
    output logic     issuable,
    output logic     fillable
);
    // decode the code's class
    always_comb begin
        issuable = (code != CYC_RESERVED);
        fillable = code[BIT_MIO] & ~code[BIT_WR];
    end
endmodule

// File: rtl/lbc_lock_track.sv
// Tracks a locked read-modify-write run and drives the active-low lock.
// Assumes: start pulses once per accepted cycle and done pulses on the ready
// of the cycle in progress. Lock is released only by the ready of a cycle
// marked as the end of the run.
module lbc_lock_track (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic want_lock,
    input  logic want_end,
    input  logic done,
    output logic lock_n
);
    logic end_pending;
    logic joins;

    // a cycle is locked if it asks to be, or a run is already open
    always_comb joins = want_lock | ~lock_n;

    // lock level and end-of-run flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_n      <= 1'b1;
            end_pending <= 1'b0;
        end else if (start) begin
            lock_n      <= ~joins;
            end_pending <= joins & want_end;
        end else if (done && end_pending) begin
            lock_n      <= 1'b1;
            end_pending <= 1'b0;
        end
    end

    // R5: lock releases only following a completed cycle
    p_release_on_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_n) |-> $past(done));
    // R4: a lock request at acceptance asserts lock in the strobe clock
    p_lock_at_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && want_lock) |=> !lock_n);
endmodule

// File: rtl/lbc_bus_fsm.sv
// Bus cycle sequencer: accepts a request when the bus is free, issues a
// one-clock strobe with the cycle code, waits for ready, and grants full
// bus hold between cycles when no lock is open.
// Assumes: ready is meaningful only while a cycle is in progress.
module lbc_bus_fsm
    import lbc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_valid,
    input  cyc_def_t req_type,
    input  logic     req_ok,
    input  logic     bus_ready,
    input  logic     hold_req,
    input  logic     ahold_req,
    input  logic     locked,
    output logic     accept,
    output logic     done,
    output logic     busy,
    output logic     ads_n,
    output cyc_def_t cyc_def,
    output logic     hold_ack
);
    seq_state_t state;
    logic       grant_hold;

    // decide hold grant and request acceptance in the idle state
    always_comb begin
        grant_hold = (state == ST_IDLE) && hold_req && !locked;
        accept     = (state == ST_IDLE) && req_valid && req_ok
                     && !ahold_req && !grant_hold;
        done       = (state == ST_BUSY) && bus_ready;
        busy       = (state == ST_BUSY);
        hold_ack   = (state == ST_HOLD);
    end

    // state, strobe and cycle code registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ads_n   <= 1'b1;
            cyc_def <= '0;
        end else begin
            ads_n <= 1'b1;
            unique case (state)
                ST_IDLE: begin
                    if (grant_hold) begin
                        state <= ST_HOLD;
                    end else if (accept) begin
                        state   <= ST_BUSY;
                        ads_n   <= 1'b0;
                        cyc_def <= req_type;
                    end
                end
                ST_BUSY: if (bus_ready) state <= ST_IDLE;
                ST_HOLD: if (!hold_req) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: the strobe lasts a single clock
    p_ads_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_n |=> ads_n);
    // R3: the reserved code never accompanies a strobe
    p_no_reserved_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_n |-> cyc_def != CYC_RESERVED);
    // R1: the code holds steady outside the strobe clock
    p_def_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ads_n |-> $stable(cyc_def));
endmodule

// File: rtl/lockbus_seq.sv
// Top of the locked bus cycle sequencer. Joins the code decoder, the bus
// sequencer and the lock tracker, and forms the drive enables and the
// cache-fill indication.
// Assumes: tristate drivers outside use bus_oe and addr_oe.
module lockbus_seq
    import lbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [DEF_W-1:0] req_type,
    input  logic             req_lock,
    input  logic             req_lock_end,
    output logic             req_accept,
    input  logic             bus_ready,
    input  logic             hold_req,
    input  logic             ahold_req,
    input  logic             cache_en,
    output logic             ads_n,
    output logic [DEF_W-1:0] cyc_def,
    output logic             lock_n,
    output logic             hold_ack,
    output logic             bus_oe,
    output logic             addr_oe,
    output logic             cache_fill
);
    logic req_ok, req_fill_unused, cur_ok_unused, cur_fill;
    logic done, busy;

    lbc_cycle_decode i_req_dec (
        .code(req_type), .issuable(req_ok), .fillable(req_fill_unused));

    lbc_cycle_decode i_cur_dec (
        .code(cyc_def), .issuable(cur_ok_unused), .fillable(cur_fill));

    lbc_bus_fsm i_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
        .req_ok(req_ok), .bus_ready(bus_ready), .hold_req(hold_req),
        .ahold_req(ahold_req), .locked(~lock_n), .accept(req_accept),
        .done(done), .busy(busy), .ads_n(ads_n), .cyc_def(cyc_def),
        .hold_ack(hold_ack));

    lbc_lock_track i_lock (
        .clk(clk), .rst_n(rst_n), .start(req_accept), .want_lock(req_lock),
        .want_end(req_lock_end), .done(done), .lock_n(lock_n));

    // drive enables and cache-fill decision
    always_comb begin
        bus_oe     = ~hold_ack;
        addr_oe    = ~hold_ack & ~ahold_req;
        cache_fill = busy & cur_fill & cache_en & lock_n;
    end

    // R6: hold is never granted while lock is asserted
    p_no_hold_in_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> lock_n);
    // R10: a cache fill never happens under lock
    p_fill_unlocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cache_fill |-> lock_n);
    // R7: address hold blocks the next strobe
    p_ahold_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ahold_req |=> ads_n);
    // R8: hold is granted only after a clock with no lock and no strobe
    p_hold_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack) |-> ($past(lock_n) && $past(ads_n)));
endmodule

// File: tb/test_lockbus_seq.sv
module test_lockbus_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_lock = 1'b0, req_lock_end = 1'b0;
    logic [2:0] req_type = 3'b000;
    logic       bus_ready = 1'b0, hold_req = 1'b0, ahold_req = 1'b0, cache_en = 1'b0;
    logic       req_accept, ads_n, lock_n, hold_ack, bus_oe, addr_oe, cache_fill;
    logic [2:0] cyc_def;

    int errors = 0;
    int checks = 0;
    bit done_flag = 1'b0;

    // reference model state
    int         m_st = 0;   // 0 idle, 1 busy, 2 hold
    logic       m_ads_n = 1'b1, m_lock_n = 1'b1, m_end = 1'b0;
    logic [2:0] m_def = 3'b000;

    always #5 clk = ~clk;

    lockbus_seq i_lockbus_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
        .req_lock(req_lock), .req_lock_end(req_lock_end), .req_accept(req_accept),
        .bus_ready(bus_ready), .hold_req(hold_req), .ahold_req(ahold_req),
        .cache_en(cache_en), .ads_n(ads_n), .cyc_def(cyc_def), .lock_n(lock_n),
        .hold_ack(hold_ack), .bus_oe(bus_oe), .addr_oe(addr_oe),
        .cache_fill(cache_fill));

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_accept();
        return (m_st == 0) && req_valid && (req_type != 3'b101) && !ahold_req
               && !(hold_req && m_lock_n);
    endfunction

    function automatic logic exp_fill();
        return (m_st == 1) && m_def[2] && !m_def[0] && m_lock_n && cache_en;
    endfunction

    // one clock: inputs are already driven at a falling edge
    task automatic step();
        logic acc, lk;
        #1;
        if (rst_n) begin
            acc = exp_accept();
            chk("R2/R3/R6/R7/R8/R9 accept", {7'd0, req_accept}, {7'd0, acc});
            chk("R10 cache_fill", {7'd0, cache_fill}, {7'd0, exp_fill()});
            chk("R7/R9 addr_oe", {7'd0, addr_oe}, {7'd0, (m_st != 2) && !ahold_req});
        end
        @(posedge clk);
        if (!rst_n) begin
            m_st = 0; m_ads_n = 1'b1; m_lock_n = 1'b1; m_end = 1'b0; m_def = 3'b000;
        end else begin
            acc = exp_accept();
            case (m_st)
                0: begin
                    if (hold_req && m_lock_n) m_st = 2;
                    else if (acc) begin
                        lk = req_lock || !m_lock_n;
                        m_st = 1; m_ads_n = 1'b0; m_def = req_type;
                        m_lock_n = !lk; m_end = lk && req_lock_end;
                    end
                end
                1: begin
                    m_ads_n = 1'b1;
                    if (bus_ready) begin
                        m_st = 0;
                        if (m_end) begin m_lock_n = 1'b1; m_end = 1'b0; end
                    end
                end
                default: if (!hold_req) m_st = 0;
            endcase
        end
        @(negedge clk);
        chk("R1/R2 ads_n", {7'd0, ads_n}, {7'd0, m_ads_n});
        chk("R1 cyc_def", {5'd0, cyc_def}, {5'd0, m_def});
        chk("R4/R5 lock_n", {7'd0, lock_n}, {7'd0, m_lock_n});
        chk("R6/R8/R9 hold_ack", {7'd0, hold_ack}, {7'd0, m_st == 2});
        chk("R9 bus_oe", {7'd0, bus_oe}, {7'd0, m_st != 2});
    endtask

    task automatic drive(input logic v, input logic [2:0] t, input logic lk, input logic le,
                         input logic rdy, input logic hr, input logic ah, input logic ce);
        req_valid = v; req_type = t; req_lock = lk; req_lock_end = le;
        bus_ready = rdy; hold_req = hr; ahold_req = ah; cache_en = ce;
        step();
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        drive(1, 3'b110, 1, 0, 1, 1, 0, 1);
        drive(1, 3'b110, 1, 0, 1, 1, 0, 1);
        // R11: reset values
        chk("R11 ads_n", {7'd0, ads_n}, 8'd1);
        chk("R11 lock_n", {7'd0, lock_n}, 8'd1);
        chk("R11 hold_ack", {7'd0, hold_ack}, 8'd0);
        chk("R11 cyc_def", {5'd0, cyc_def}, 8'd0);
        rst_n = 1'b1;
        // R3: reserved code is ignored
        drive(1, 3'b101, 1, 0, 0, 0, 0, 0);
        chk("R3 no strobe", {7'd0, ads_n}, 8'd1);
        chk("R3 lock untouched", {7'd0, lock_n}, 8'd1);
        // R4 R5 R6 R7 R10: locked read, hold raised mid-run, ahold honoured
        drive(1, 3'b110, 1, 0, 0, 0, 0, 1);
        chk("R4 lock in strobe clock", {7'd0, lock_n}, 8'd0);
        drive(0, 3'b000, 0, 0, 1, 1, 0, 1);   // locked read, no fill (R10)
        drive(1, 3'b111, 0, 1, 0, 1, 1, 0);   // ahold blocks accept (R7)
        drive(1, 3'b111, 0, 1, 0, 1, 0, 0);   // R6: accepted despite hold
        chk("R6 hold refused", {7'd0, hold_ack}, 8'd0);
        drive(0, 3'b000, 0, 0, 1, 1, 0, 0);
        chk("R5 lock released", {7'd0, lock_n}, 8'd1);
        drive(1, 3'b110, 0, 0, 0, 1, 0, 0);   // R8: hold wins over request
        chk("R8 hold granted", {7'd0, hold_ack}, 8'd1);
        drive(1, 3'b110, 0, 0, 0, 0, 0, 1);   // R9: no accept during hold, release
        drive(1, 3'b100, 0, 0, 0, 0, 0, 1);   // unlocked code read
        drive(0, 3'b000, 0, 0, 0, 0, 0, 1);   // R10: fill shown
        drive(0, 3'b000, 0, 0, 1, 0, 0, 1);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            drive(($urandom % 4) != 0, 3'($urandom), ($urandom % 3) == 0,
                  ($urandom % 3) == 0, ($urandom % 3) == 0, ($urandom % 6) == 0,
                  ($urandom % 8) == 0, ($urandom % 2) == 0);
        end
        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule